// File: doc/BRIEF.md
# Thread Yield Control Unit

This unit carries out the yield operation for one calling hardware thread context. A request carries a signed 32-bit operand, a 32-bit qualifier mask, the caller's context identity and status bits, and the current value of the caller's virtual-processor control word. The operand's value alone picks the action. A zero operand asks the caller to give up its activation. A positive operand names wait-condition bits that must all lie inside the mask. A negative operand other than -2 asks whether yielding is allowed at all. An operand of -2 is accepted with no check.

For a zero operand the unit walks the thread-context table one entry per cycle. It looks for an entry whose processor and context numbers equal the caller's and that is dynamically allocated, not halted and activated. If such an entry exists, the caller's activated bit is cleared. A failing check writes a path-specific cause code into the exception field of the control word and raises the fault flag. Every other bit of that word is kept. The returned result is always the operand ANDed with the mask. The unit does not reschedule other threads.

Requests enter on a valid/ready channel. `req_ready` is high only while the unit is idle, so one request at a time is in flight. Request inputs are sampled on the accepting edge. The context table must stay stable until the response appears. The response is held unchanged, with `rsp_valid` high, until `rsp_ready` is seen high at a clock edge. `rsp_fault` is meaningful, and high, only together with `rsp_valid`. With `rsp_ready` tied high it is therefore a one-cycle pulse marking completion.

Top module: `yield_unit`

## Requirements
- R1: `rsp_result` equals the accepted operand bitwise ANDed with the accepted mask, for every operand value.
- R2: A positive operand (bit 31 clear, nonzero) with any bit set where the mask is 0 gives `rsp_fault`=1, and the exception field (bits EXC_LO+2..EXC_LO, default 18..16) of `rsp_vpe_ctrl` holds 2.
- R3: A positive operand whose set bits all lie inside the mask gives `rsp_fault`=0 and `rsp_vpe_ctrl` equal to the accepted control word.
- R4: A negative operand other than -2 gives `rsp_fault`=1 with exception field 4 exactly when control-word bit YSI_BIT (default 21) and `caller_dirty` are both 1. Otherwise there is no fault and the word is unchanged.
- R5: An operand of -2 (0xFFFFFFFE) never faults and leaves the control word unchanged, whatever YSI and dirty are.
- R6: For a zero operand, `rsp_caller_active` is `caller_active` cleared exactly when some context with index 0..`ctx_last` has processor number = `caller_vpe`, context number = `caller_tc`, `ctx_da`=1, `ctx_halt`=0 and `ctx_act`=1. Contexts above `ctx_last` have no effect.
- R7: On a fault only the three exception-field bits of the control word change; all other 29 bits equal the accepted word.
- R8: A zero operand never faults and leaves the control word unchanged. A nonzero operand returns `rsp_caller_active` equal to `caller_active`.
- R9: After the accepting edge, `rsp_valid` rises 1 cycle later for a nonzero operand and `ctx_last`+2 cycles later for a zero operand. `req_ready` is low from acceptance until the response is taken.
- R10: While `rsp_valid`=1 and `rsp_ready`=0, all response outputs hold their values. `rsp_fault` is never 1 without `rsp_valid`.
- R11: After reset, `req_ready`=1, `rsp_valid`=0 and `rsp_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle and able to accept |
| req_operand | input | 32 | Signed yield operand |
| req_mask | input | 32 | Yield qualifier mask |
| caller_vpe | input | VPE_W | Caller's virtual processor number |
| caller_tc | input | TC_W | Caller's thread-context number |
| caller_active | input | 1 | Caller's activated bit |
| caller_dirty | input | 1 | Caller's dirty-context bit |
| vpe_ctrl_in | input | 32 | Caller's processor control word |
| ctx_last | input | IDX_W | Highest context index to scan (configured count minus one) |
| ctx_vpe | input | NUM_CTX*VPE_W | Processor number of each context, entry i at bits i*VPE_W |
| ctx_tc | input | NUM_CTX*TC_W | Context number of each context, entry i at bits i*TC_W |
| ctx_da | input | NUM_CTX | Dynamically-allocated flag per context |
| ctx_halt | input | NUM_CTX | Halted flag per context |
| ctx_act | input | NUM_CTX | Activated flag per context |
| rsp_valid | output | 1 | Response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_result | output | 32 | Operand AND mask |
| rsp_fault | output | 1 | Thread fault raised by this request |
| rsp_vpe_ctrl | output | 32 | Updated control word |
| rsp_caller_active | output | 1 | Updated caller activated bit |

## Verification
Nonzero operands are due on the first falling edge after the accepting edge. Zero operands are due `ctx_last`+2 falling edges after it, one for each scanned entry plus one. The bench counts falling edges from acceptance to the first one that shows `rsp_valid`, and compares that count with the expected latency before it looks at any data. All outputs are sampled on falling edges, away from the edge where they change. On stalled responses the bench samples twice more while `rsp_ready` is low. It then confirms, one falling edge after the handshake edge, that the unit is idle again.

// File: rtl/yield_pkg.sv
package yield_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned CAUSE_W = 3;

  localparam logic [CAUSE_W-1:0] CAUSE_NONE = 3'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_QUAL = 3'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_DENY = 3'd4;

  localparam logic [WORD_W-1:0] OPERAND_SKIP = 32'hFFFF_FFFE;

  typedef enum logic [1:0] {
    KIND_DEACT  = 2'd0,
    KIND_QUAL   = 2'd1,
    KIND_PERMIT = 2'd2,
    KIND_SKIP   = 2'd3
  } yield_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_RESP = 2'd2
  } yield_state_e;
endpackage

// File: rtl/yield_classify.sv
module yield_classify
  import yield_pkg::*;
(
  input  logic [WORD_W-1:0]  operand,
  input  logic [WORD_W-1:0]  mask,
  input  logic               ysi,
  input  logic               dirty,
  output yield_kind_e        kind,
  output logic               fault,
  output logic [CAUSE_W-1:0] cause,
  output logic [WORD_W-1:0]  result
);
  always_comb begin
    if (operand == '0)               kind = KIND_DEACT;
    else if (!operand[WORD_W-1])     kind = KIND_QUAL;
    else if (operand == OPERAND_SKIP) kind = KIND_SKIP;
    else                             kind = KIND_PERMIT;
  end

  always_comb begin
    fault = 1'b0;
    cause = CAUSE_NONE;
    unique case (kind)
      KIND_QUAL: begin
        if ((operand & ~mask) != '0) begin
          fault = 1'b1;
          cause = CAUSE_QUAL;
        end
      end
      KIND_PERMIT: begin
        if (ysi && dirty) begin
          fault = 1'b1;
          cause = CAUSE_DENY;
        end
      end
      default: begin
        fault = 1'b0;
        cause = CAUSE_NONE;
      end
    endcase
  end

  assign result = operand & mask;
endmodule

// File: rtl/yield_ctx_scan.sv
module yield_ctx_scan #(
  parameter int unsigned NUM_CTX = 4,
  parameter int unsigned VPE_W   = 4,
  parameter int unsigned TC_W    = 8,
  parameter int unsigned IDX_W   = 2
) (
  input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe,
  input  logic [NUM_CTX*TC_W-1:0]  ctx_tc,
  input  logic [NUM_CTX-1:0]       ctx_da,
  input  logic [NUM_CTX-1:0]       ctx_halt,
  input  logic [NUM_CTX-1:0]       ctx_act,
  input  logic [VPE_W-1:0]         want_vpe,
  input  logic [TC_W-1:0]          want_tc,
  input  logic [IDX_W-1:0]         idx,
  output logic                     hit
);
  logic [NUM_CTX-1:0] eligible;

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_entry
    logic id_eq;
    assign id_eq = (ctx_vpe[g*VPE_W +: VPE_W] == want_vpe) &&
                   (ctx_tc[g*TC_W +: TC_W] == want_tc);
    assign eligible[g] = id_eq && ctx_da[g] && !ctx_halt[g] && ctx_act[g];
  end

  assign hit = eligible[idx];
endmodule

// File: rtl/yield_unit.sv
module yield_unit
  import yield_pkg::*;
#(
  parameter int unsigned NUM_CTX = 4,
  parameter int unsigned VPE_W   = 4,
  parameter int unsigned TC_W    = 8,
  parameter int unsigned YSI_BIT = 21,
  parameter int unsigned EXC_LO  = 16,
  localparam int unsigned IDX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [31:0]              req_operand,
  input  logic [31:0]              req_mask,
  input  logic [VPE_W-1:0]         caller_vpe,
  input  logic [TC_W-1:0]          caller_tc,
  input  logic                     caller_active,
  input  logic                     caller_dirty,
  input  logic [31:0]              vpe_ctrl_in,
  input  logic [IDX_W-1:0]         ctx_last,
  input  logic [NUM_CTX*VPE_W-1:0] ctx_vpe,
  input  logic [NUM_CTX*TC_W-1:0]  ctx_tc,
  input  logic [NUM_CTX-1:0]       ctx_da,
  input  logic [NUM_CTX-1:0]       ctx_halt,
  input  logic [NUM_CTX-1:0]       ctx_act,
  output logic                     rsp_valid,
  input  logic                     rsp_ready,
  output logic [31:0]              rsp_result,
  output logic                     rsp_fault,
  output logic [31:0]              rsp_vpe_ctrl,
  output logic                     rsp_caller_active
);
  localparam logic [IDX_W-1:0]  LAST_MAX = IDX_W'(NUM_CTX - 1);
  localparam logic [WORD_W-1:0] EXC_MASK = WORD_W'((1 << CAUSE_W) - 1) << EXC_LO;

  yield_state_e        state_q;
  logic [IDX_W-1:0]    idx_q, last_q;
  logic                found_q, act_q, fault_q;
  logic [WORD_W-1:0]   result_q, vctl_q;
  logic [VPE_W-1:0]    vpe_q;
  logic [TC_W-1:0]     tc_q;

  yield_kind_e         cls_kind;
  logic                cls_fault;
  logic [CAUSE_W-1:0]  cls_cause;
  logic [WORD_W-1:0]   cls_result;
  logic                scan_hit;
  logic                accept;
  logic                scan_done;

  yield_classify u_classify (
    .operand (req_operand),
    .mask    (req_mask),
    .ysi     (vpe_ctrl_in[YSI_BIT]),
    .dirty   (caller_dirty),
    .kind    (cls_kind),
    .fault   (cls_fault),
    .cause   (cls_cause),
    .result  (cls_result)
  );

  yield_ctx_scan #(
    .NUM_CTX (NUM_CTX),
    .VPE_W   (VPE_W),
    .TC_W    (TC_W),
    .IDX_W   (IDX_W)
  ) u_scan (
    .ctx_vpe  (ctx_vpe),
    .ctx_tc   (ctx_tc),
    .ctx_da   (ctx_da),
    .ctx_halt (ctx_halt),
    .ctx_act  (ctx_act),
    .want_vpe (vpe_q),
    .want_tc  (tc_q),
    .idx      (idx_q),
    .hit      (scan_hit)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign scan_done = (idx_q == last_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      idx_q    <= '0;
      last_q   <= '0;
      found_q  <= 1'b0;
      act_q    <= 1'b0;
      fault_q  <= 1'b0;
      result_q <= '0;
      vctl_q   <= '0;
      vpe_q    <= '0;
      tc_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            result_q <= cls_result;
            fault_q  <= cls_fault;
            vctl_q   <= cls_fault
                        ? ((vpe_ctrl_in & ~EXC_MASK) | (WORD_W'(cls_cause) << EXC_LO))
                        : vpe_ctrl_in;
            act_q    <= caller_active;
            vpe_q    <= caller_vpe;
            tc_q     <= caller_tc;
            found_q  <= 1'b0;
            idx_q    <= '0;
            last_q   <= (ctx_last > LAST_MAX) ? LAST_MAX : ctx_last;
            state_q  <= (cls_kind == KIND_DEACT) ? ST_SCAN : ST_RESP;
          end
        end
        ST_SCAN: begin
          found_q <= found_q | scan_hit;
          if (scan_done) begin
            act_q   <= act_q & ~(found_q | scan_hit);
            state_q <= ST_RESP;
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        ST_RESP: begin
          if (rsp_ready) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid         = (state_q == ST_RESP);
  assign rsp_fault         = rsp_valid && fault_q;
  assign rsp_result        = result_q;
  assign rsp_vpe_ctrl      = vctl_q;
  assign rsp_caller_active = act_q;
endmodule

// File: rtl/yield_unit_chk.sv
module yield_unit_chk #(
  parameter int unsigned EXC_LO = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic [31:0] req_operand,
  input logic [31:0] req_mask,
  input logic        caller_active,
  input logic [31:0] vpe_ctrl_in,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [31:0] rsp_result,
  input logic        rsp_fault,
  input logic [31:0] rsp_vpe_ctrl,
  input logic        rsp_caller_active
);
  localparam logic [31:0] FIELD = 32'h7 << EXC_LO;

  logic [31:0] cap_and, cap_vctl;
  logic        cap_nonzero, cap_act;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cap_and     <= '0;
      cap_vctl    <= '0;
      cap_nonzero <= 1'b0;
      cap_act     <= 1'b0;
    end else if (req_valid && req_ready) begin
      cap_and     <= req_operand & req_mask;
      cap_vctl    <= vpe_ctrl_in;
      cap_nonzero <= (req_operand != '0);
      cap_act     <= caller_active;
    end
  end

  AST_RESULT_IS_AND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_result == cap_and); // R1

  AST_FAULT_CAUSE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_vpe_ctrl[EXC_LO +: 3] == 3'd2 || rsp_vpe_ctrl[EXC_LO +: 3] == 3'd4)); // R2

  AST_OTHER_BITS_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_vpe_ctrl & ~FIELD) == (cap_vctl & ~FIELD)); // R7

  AST_NO_FAULT_WORD_SAME: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_vpe_ctrl == cap_vctl); // R7

  AST_NONZERO_KEEPS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && cap_nonzero) |-> rsp_caller_active == cap_act); // R8

  AST_ZERO_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !cap_nonzero) |-> !rsp_fault); // R8

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready); // R9

  AST_FAULT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> rsp_valid); // R10

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_result) && $stable(rsp_fault)
                                   && $stable(rsp_vpe_ctrl) && $stable(rsp_caller_active))); // R10
endmodule

bind yield_unit yield_unit_chk #(.EXC_LO(EXC_LO)) u_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .req_valid         (req_valid),
  .req_ready         (req_ready),
  .req_operand       (req_operand),
  .req_mask          (req_mask),
  .caller_active     (caller_active),
  .vpe_ctrl_in       (vpe_ctrl_in),
  .rsp_valid         (rsp_valid),
  .rsp_ready         (rsp_ready),
  .rsp_result        (rsp_result),
  .rsp_fault         (rsp_fault),
  .rsp_vpe_ctrl      (rsp_vpe_ctrl),
  .rsp_caller_active (rsp_caller_active)
);

// File: tb/yield_unit_tb_top.sv
module yield_unit_tb_top;
  localparam int NC   = 4;
  localparam int VW   = 2;
  localparam int TW   = 2;
  localparam int IW   = 2;
  localparam int YSI  = 21;
  localparam int EXC  = 16;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic           req_valid = 1'b0;
  logic           req_ready;
  logic [31:0]    req_operand = '0;
  logic [31:0]    req_mask = '0;
  logic [VW-1:0]  caller_vpe = '0;
  logic [TW-1:0]  caller_tc = '0;
  logic           caller_active = 1'b0;
  logic           caller_dirty = 1'b0;
  logic [31:0]    vpe_ctrl_in = '0;
  logic [IW-1:0]  ctx_last = '0;
  logic [NC*VW-1:0] ctx_vpe = '0;
  logic [NC*TW-1:0] ctx_tc = '0;
  logic [NC-1:0]  ctx_da = '0;
  logic [NC-1:0]  ctx_halt = '0;
  logic [NC-1:0]  ctx_act = '0;
  logic           rsp_valid;
  logic           rsp_ready = 1'b1;
  logic [31:0]    rsp_result;
  logic           rsp_fault;
  logic [31:0]    rsp_vpe_ctrl;
  logic           rsp_caller_active;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int seq = 0;

  yield_unit #(.NUM_CTX(NC), .VPE_W(VW), .TC_W(TW), .YSI_BIT(YSI), .EXC_LO(EXC)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WDOG) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected<=%0d", cycles, WDOG);
      finish_run();
    end
  end

  // One transaction; expected values are passed in.
  task automatic run_req(input logic [31:0] op, input logic [31:0] msk, input logic dirty,
                         input logic act, input logic [31:0] vctl, input int exp_lat,
                         input logic exp_fault, input logic [31:0] exp_vctl,
                         input logic exp_act, input bit stall, input string tag);
    int lat;
    @(negedge clk);
    chk(req_ready === 1'b1, "R9 idle ready", {31'd0, req_ready}, 32'd1);
    req_operand   = op;
    req_mask      = msk;
    caller_dirty  = dirty;
    caller_active = act;
    vpe_ctrl_in   = vctl;
    rsp_ready     = stall ? 1'b0 : 1'b1;
    req_valid     = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req_valid   = 1'b0;
    req_operand = $urandom;
    req_mask    = $urandom;
    vpe_ctrl_in = $urandom;
    caller_active = ~act;
    lat = 1;
    while (rsp_valid !== 1'b1 && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, {"R9 latency ", tag}, lat, exp_lat);
    chk(rsp_result === (op & msk), {"R1 result ", tag}, rsp_result, op & msk);
    chk(rsp_fault === exp_fault, {"fault ", tag}, {31'd0, rsp_fault}, {31'd0, exp_fault});
    chk(rsp_vpe_ctrl === exp_vctl, {"R7 control word ", tag}, rsp_vpe_ctrl, exp_vctl);
    chk(rsp_caller_active === exp_act, {"active ", tag}, {31'd0, rsp_caller_active}, {31'd0, exp_act});
    if (stall) begin
      @(negedge clk);
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_result === (op & msk) && rsp_fault === exp_fault
          && rsp_vpe_ctrl === exp_vctl, {"R10 hold ", tag}, rsp_vpe_ctrl, exp_vctl);
      rsp_ready = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
    chk(rsp_valid === 1'b0 && rsp_fault === 1'b0 && req_ready === 1'b1,
        {"R10 release ", tag}, {30'd0, rsp_valid, rsp_fault}, 32'd0);
  endtask

  function automatic logic [31:0] put_cause(input logic [31:0] w, input logic [2:0] c);
    logic [31:0] r;
    r = w;
    r[EXC +: 3] = c;
    return r;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(req_ready === 1'b1 && rsp_valid === 1'b0 && rsp_fault === 1'b0, "R11 reset state",
        {29'd0, req_ready, rsp_valid, rsp_fault}, 32'h4);
    rst_n = 1'b1;

    // R2/R3: positive operands, exhaustive over a 4-bit corner
    for (int op = 1; op < 16; op++) begin
      for (int m = 0; m < 16; m++) begin
        logic [31:0] w;
        logic [31:0] o32, m32;
        bit f;
        seq++;
        o32 = 32'(op) | ((op[0]) ? 32'h0010_0000 : 32'h0);
        m32 = 32'(m) | ((m[1]) ? 32'h0010_0000 : 32'h0) | 32'h8000_0000;
        w = 32'h5A3C_96E1 ^ 32'(seq * 32'h0101_0101);
        f = ((o32 & ~m32) != 0);
        run_req(o32, m32, 1'b1, m[0], w, 1, f, f ? put_cause(w, 3'd2) : w, m[0],
                (seq % 7) == 0, f ? "R2 outside mask" : "R3 inside mask");
      end
    end
    run_req(32'h7FFF_FFFF, 32'hFFFF_FFFF, 1'b0, 1'b1, 32'h0000_0000, 1, 1'b0, 32'h0, 1'b1, 1'b0, "R3 max positive");
    run_req(32'h7FFF_FFFF, 32'hFFFF_FFFE, 1'b0, 1'b1, 32'hFFFF_FFFF, 1, 1'b1,
            put_cause(32'hFFFF_FFFF, 3'd2), 1'b1, 1'b1, "R2 max positive");

    // R4/R5: negative operands
    begin
      logic [31:0] negs [5];
      negs = '{32'hFFFF_FFFF, 32'hFFFF_FFFE, 32'hFFFF_FFFD, 32'h8000_0000, 32'hC001_2345};
      for (int k = 0; k < 5; k++) begin
        for (int y = 0; y < 2; y++) begin
          for (int d = 0; d < 2; d++) begin
            logic [31:0] w;
            bit f;
            w = 32'h1357_9BDF;
            w[YSI] = y[0];
            f = (negs[k] != 32'hFFFF_FFFE) && y[0] && d[0];
            run_req(negs[k], 32'h0F0F_F0F0, d[0], 1'b1, w, 1, f, f ? put_cause(w, 3'd4) : w, 1'b1,
                    (k == 3), (negs[k] == 32'hFFFF_FFFE) ? "R5 skip operand" : "R4 permit check");
          end
        end
      end
    end

    // R6/R8: zero operand scans
    caller_vpe = 2'd1;
    caller_tc  = 2'd2;
    for (int last = 0; last < NC; last++) begin
      for (int p = 0; p < NC; p++) begin
        for (int v = 0; v < 6; v++) begin
          for (int ca = 0; ca < 2; ca++) begin
            bit found;
            logic [31:0] w;
            ctx_last = IW'(last);
            for (int i = 0; i < NC; i++) begin
              ctx_vpe[i*VW +: VW] = 2'd3;
              ctx_tc[i*TW +: TW]  = 2'd3;
              ctx_da[i] = 1'b1;
              ctx_halt[i] = 1'b0;
              ctx_act[i] = 1'b1;
            end
            ctx_vpe[p*VW +: VW] = (v == 4) ? 2'd0 : 2'd1;
            ctx_tc[p*TW +: TW]  = (v == 5) ? 2'd1 : 2'd2;
            if (v == 1) ctx_da[p] = 1'b0;
            if (v == 2) ctx_halt[p] = 1'b1;
            if (v == 3) ctx_act[p] = 1'b0;
            found = (v == 0) && (p <= last);
            w = 32'hFFFF_FFFF ^ 32'(last * 16 + p);
            run_req(32'h0, 32'hFFFF_FFFF, 1'b1, ca[0], w, last + 2, 1'b0, w,
                    ca[0] & ~found, (p == 1 && v == 0 && ca == 1),
                    (p > last) ? "R6 beyond last ignored" : "R6 R8 deactivate scan");
          end
        end
      end
    end

    finish_run();
  end
endmodule